// File: doc/BRIEF.md
# Program Counter with Interrupt Vectoring and Return Stack

This block holds the 11-bit instruction address of a small processor core that runs from a 2K-word program store. The address is split into an 8-bit low byte and a 3-bit high part. Each cycle the instruction decoder selects one operation: hold, step forward, jump, call, return, or return from interrupt. It can also select a computed jump, which adds the accumulator to the low byte or subtracts it from the low byte. An interrupt-take strobe from the interrupt logic overrides the selected operation. It saves the current address and sends execution to the fixed interrupt vector.

Return addresses live in an eight-entry circular stack. The block reports the stack depth, a full flag and a sticky overflow flag. It also keeps the global interrupt enable. Taking an interrupt clears the enable, and only an interrupt return sets it again. The two computed jumps behave differently on purpose. A carry out of the low byte moves into the high part. A borrow does not, so a subtraction only wraps within the current 256-word page.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the address is 000h, the stack depth is 0, the full and overflow flags are 0 and the interrupt enable is 0.
- R2: Operation code 0 holds the address. Code 1 adds one to the whole 11-bit address, so 7FFh goes to 000h.
- R3: Code 2 loads the target input as the next address, and any of the 2048 addresses can be reached.
- R4: Code 3 pushes the current address plus one and loads the target. Code 4 pops the newest entry into the address, so returns come back in last-in-first-out order.
- R5: When irq_take is high, the selected operation is ignored. The current address, without the increment, is pushed, the next address is 008h and the interrupt enable is cleared.
- R6: Code 5 pops like code 4 and also sets the interrupt enable. Code 4 leaves the interrupt enable unchanged.
- R7: Code 6 adds the accumulator to the low byte. A carry out of bit 7 adds one to the 3-bit high part, and a carry out of the high part is dropped, so 7FFh plus 1 gives 000h.
- R8: Code 7 subtracts the accumulator from the low byte modulo 256. The high part keeps its value even when the subtraction borrows.
- R9: Every push raises the depth by one up to a limit of 8, and every pop lowers it by one down to 0. The full flag is high exactly when the depth is 8.
- R10: A push at depth 8 overwrites the oldest entry and sets the overflow flag, which stays set until reset. The eight pops that follow return the eight newest entries, newest first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation select (codes listed in R2 to R8) |
| target | input | 11 | Jump or call destination |
| acc | input | 8 | Accumulator value for computed jumps |
| irq_take | input | 1 | Interrupt accepted this cycle |
| pc | output | 11 | Current instruction address |
| stk_depth | output | 4 | Number of valid stack entries |
| stk_full | output | 1 | Stack holds eight entries |
| stk_ovf | output | 1 | Sticky flag for a push made at full depth |
| gie | output | 1 | Global interrupt enable |

## Verification
A wrong stack pointer does not change pc until the next return. The error then shows as an address out of order, or as a depth that disagrees with the number of pushes minus pops. A wrong carry or borrow path shows on the very next cycle in pc bits 10:8. The sweeps cover every high part and a spread of low bytes and accumulator values, including the wrap at the top of the address space. A wrong interrupt priority shows one cycle after the strobe, as pc not equal to 008h, and it shows again at the matching interrupt return.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W  = 11,
  parameter int LOW_W   = 8,
  parameter int DEPTH   = 8,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    op,
  input  logic [ADDR_W-1:0]             target,
  input  logic [LOW_W-1:0]              acc,
  input  logic                          irq_take,
  output logic [ADDR_W-1:0]             pc,
  output logic [$clog2(DEPTH+1)-1:0]    stk_depth,
  output logic                          stk_full,
  output logic                          stk_ovf,
  output logic                          gie
);
  localparam int HIGH_W = ADDR_W - LOW_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  localparam logic [2:0] OP_HOLD = 3'd0;
  localparam logic [2:0] OP_INC  = 3'd1;
  localparam logic [2:0] OP_JMP  = 3'd2;
  localparam logic [2:0] OP_CALL = 3'd3;
  localparam logic [2:0] OP_RET  = 3'd4;
  localparam logic [2:0] OP_RETI = 3'd5;
  localparam logic [2:0] OP_ADDL = 3'd6;
  localparam logic [2:0] OP_SUBL = 3'd7;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] pc_q, pc_d, push_val;
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q, gie_q;
  logic              push, pop;
  logic [ADDR_W-1:0] stk [DEPTH];

  wire [LOW_W-1:0]  lo      = pc_q[LOW_W-1:0];
  wire [HIGH_W-1:0] hi      = pc_q[ADDR_W-1:LOW_W];
  wire [LOW_W:0]    add_sum = {1'b0, lo} + {1'b0, acc};
  wire [LOW_W-1:0]  sub_lo  = lo - acc;
  wire [ADDR_W-1:0] pc_inc  = pc_q + 1'b1;
  wire [PTR_W-1:0]  ptr_dn  = ptr_q - 1'b1;
  wire [ADDR_W-1:0] top_val = stk[ptr_dn];

  always_comb begin
    pc_d     = pc_q;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc_inc;
    if (irq_take) begin
      pc_d     = ADDR_W'(IRQ_VEC);
      push     = 1'b1;
      push_val = pc_q;
    end else begin
      case (op)
        OP_HOLD: pc_d = pc_q;
        OP_INC:  pc_d = pc_inc;
        OP_JMP:  pc_d = target;
        OP_CALL: begin pc_d = target; push = 1'b1; end
        OP_RET, OP_RETI: begin pc_d = top_val; pop = 1'b1; end
        OP_ADDL: pc_d = {hi + HIGH_W'(add_sum[LOW_W]), add_sum[LOW_W-1:0]};
        OP_SUBL: pc_d = {hi, sub_lo};
        default: pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= ADDR_W'(RST_VEC);
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      gie_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (push) begin
        ptr_q <= ptr_q + 1'b1;
        if (cnt_q == FULL_CNT) ovf_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end else if (pop) begin
        ptr_q <= ptr_dn;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      if (irq_take) gie_q <= 1'b0;
      else if (op == OP_RETI) gie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk[ptr_q] <= push_val;
  end

  assign pc        = pc_q;
  assign stk_depth = cnt_q;
  assign stk_full  = (cnt_q == FULL_CNT);
  assign stk_ovf   = ovf_q;
  assign gie       = gie_q;

  a_r5_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (pc == ADDR_W'(IRQ_VEC)) && !gie);

  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_JMP) |=> pc == $past(target));

  a_r8_sub_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_SUBL) |=> pc[ADDR_W-1:LOW_W] == $past(pc[ADDR_W-1:LOW_W]));

  a_r6_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_RETI) |=> gie);

  a_r6_ret_keeps_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_RET) |=> $stable(gie));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= FULL_CNT);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  a_r10_ovf_on_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && (irq_take || op == OP_CALL)) |=> stk_ovf && stk_full);
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [10:0] target = '0;
  logic [7:0]  acc = '0;
  logic        irq_take = 1'b0;
  logic [10:0] pc;
  logic [3:0]  stk_depth;
  logic        stk_full, stk_ovf, gie;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int exp_pc;
  int pushed [16];

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .op(op), .target(target), .acc(acc),
    .irq_take(irq_take), .pc(pc), .stk_depth(stk_depth),
    .stk_full(stk_full), .stk_ovf(stk_ovf), .gie(gie));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input int t, input int a, input bit irq);
    op = o; target = 11'(t); acc = 8'(a); irq_take = irq;
    @(posedge clk);
    @(negedge clk);
    op = 3'd0; irq_take = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc in reset", int'(pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc", int'(pc), 0);
    check("R1 depth", int'(stk_depth), 0);
    check("R1 full", int'(stk_full), 0);
    check("R1 ovf", int'(stk_ovf), 0);
    check("R1 gie", int'(gie), 0);

    step(3'd0, 0, 0, 0);
    check("R2 hold", int'(pc), 0);
    for (int a = 0; a < 2048; a += 97) begin
      step(3'd2, a, 0, 0);
      check("R3 jump", int'(pc), a);
      step(3'd1, 0, 0, 0);
      check("R2 increment", int'(pc), (a + 1) % 2048);
      step(3'd0, 0, 0, 0);
      check("R2 hold", int'(pc), (a + 1) % 2048);
    end
    step(3'd2, 2047, 0, 0);
    check("R3 jump top", int'(pc), 2047);
    step(3'd1, 0, 0, 0);
    check("R2 increment wrap", int'(pc), 0);

    for (int h = 0; h < 8; h++) begin
      for (int l = 0; l < 256; l += 17) begin
        for (int a = 0; a < 256; a += 23) begin
          step(3'd2, h * 256 + l, 0, 0);
          step(3'd6, 0, a, 0);
          check("R7 add", int'(pc), (((h + (l + a) / 256) % 8) * 256) + ((l + a) % 256));
          step(3'd2, h * 256 + l, 0, 0);
          step(3'd7, 0, a, 0);
          check("R8 sub", int'(pc), h * 256 + ((l - a + 256) % 256));
        end
      end
    end
    step(3'd2, 2047, 0, 0);
    step(3'd6, 0, 1, 0);
    check("R7 add wraps high part", int'(pc), 0);
    step(3'd2, 1280, 0, 0);
    step(3'd7, 0, 1, 0);
    check("R8 borrow keeps high", int'(pc), 1535);

    step(3'd2, 256, 0, 0);
    exp_pc = 256;
    for (int k = 0; k < 8; k++) begin
      pushed[k] = (exp_pc + 1) % 2048;
      exp_pc = 512 + k * 131;
      step(3'd3, exp_pc, 0, 0);
      check("R4 call target", int'(pc), exp_pc);
      check("R9 depth up", int'(stk_depth), k + 1);
      check("R9 full flag", int'(stk_full), (k == 7) ? 1 : 0);
    end
    check("R10 no ovf yet", int'(stk_ovf), 0);
    for (int k = 7; k >= 0; k--) begin
      step(3'd4, 0, 0, 0);
      check("R4 return order", int'(pc), pushed[k]);
      check("R9 depth down", int'(stk_depth), k);
    end
    check("R6 ret keeps gie", int'(gie), 0);

    step(3'd2, 300, 0, 0);
    exp_pc = 300;
    for (int k = 0; k < 9; k++) begin
      pushed[k] = (exp_pc + 1) % 2048;
      exp_pc = 1000 + k * 7;
      step(3'd3, exp_pc, 0, 0);
    end
    check("R10 ovf set", int'(stk_ovf), 1);
    check("R9 depth saturates", int'(stk_depth), 8);
    for (int k = 8; k >= 1; k--) begin
      step(3'd4, 0, 0, 0);
      check("R10 newest eight", int'(pc), pushed[k]);
    end
    check("R9 empty after pops", int'(stk_depth), 0);
    check("R10 ovf sticky", int'(stk_ovf), 1);

    step(3'd2, 1234, 0, 0);
    step(3'd2, 77, 0, 1);
    check("R5 vector", int'(pc), 8);
    check("R5 push depth", int'(stk_depth), 1);
    check("R5 gie cleared", int'(gie), 0);
    step(3'd1, 0, 0, 0);
    step(3'd5, 0, 0, 0);
    check("R6 reti address", int'(pc), 1234);
    check("R6 reti sets gie", int'(gie), 1);
    step(3'd3, 50, 0, 0);
    step(3'd4, 0, 0, 0);
    check("R6 ret address", int'(pc), 1235);
    check("R6 ret keeps gie set", int'(gie), 1);
    step(3'd0, 0, 0, 1);
    check("R5 irq over hold", int'(pc), 8);
    check("R5 gie cleared again", int'(gie), 0);
    step(3'd5, 0, 0, 0);
    check("R5 pushed unincremented", int'(pc), 1235);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule